// File: doc/BRIEF.md
# Interrupt Status and Mask Aggregator

This block gathers the event sources of a power-management companion device into one 12-bit pending word. It combines them with a 12-bit mask word and drives a single active-high interrupt request. Eight general event inputs, a periodic-tick pulse, an alarm pulse and a time-update-error pulse each set one pending bit. A power-button level is turned into a single event on its rising edge inside the block.

Software reaches the block through a byte-wide register port. The mask and the pending word are each split across a low byte and a high nibble. Pending bits are cleared by writing ones to two acknowledge registers, which sit at their own addresses. A power-down register puts every mapped register back to its reset value. The serial front end that produces the register strobes is outside this block.

Top module: `intr_aggregator`

## Requirements
- R1: After reset the mask word is 0xFFF, the pending word is 0 and `irq_o` is low.
- R2: `irq_o` is high exactly when some pending bit is 1 and its mask bit is 0. It follows any register change from the next clock cycle onward.
- R3: Address 0x00 holds mask bits 7:0 and address 0x01 holds mask bits 11:8 in data bits 3:0. Writing one half leaves the other half unchanged. Data bits 7:4 written to 0x01 are dropped and read back as 0.
- R4: The pending word reads at 0x02 (bits 7:0) and at 0x03 (bits 11:8 in data bits 3:0, upper data bits 0). Writes to 0x02 and 0x03 have no effect.
- R5: Writing to 0x04 clears each pending bit 7:0 whose data bit is 1. Writing to 0x05 clears each pending bit 11:8 whose data bit 3:0 is 1. Both addresses read as 0.
- R6: A one-cycle pulse on `evt_misc_i[k]` sets pending bit k. `evt_tick_i` sets bit 8, `evt_alarm_i` sets bit 9 and `evt_upd_err_i` sets bit 10.
- R7: Pending bit 11 is set only when `pwr_btn_i` goes from low to high. A steady high level or a falling edge does not set it.
- R8: When an event and an acknowledge hit the same pending bit in the same cycle, the bit ends up set.
- R9: A write to 0x06 with data bit 0 set returns the mask to 0xFFF and the pending word to 0. A write to 0x06 with data bit 0 clear has no effect. Address 0x06 reads as 0.
- R10: `rdata_o` is 0 while `rd_i` is low, and any address above 0x06 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_misc_i | input | 8 | One-cycle event pulses for pending bits 7:0 |
| evt_tick_i | input | 1 | Periodic timer event pulse (bit 8) |
| evt_alarm_i | input | 1 | Alarm match event pulse (bit 9) |
| evt_upd_err_i | input | 1 | Rejected time-update event pulse (bit 10) |
| pwr_btn_i | input | 1 | Power-button level; a rising edge sets bit 11 |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Combinational read data |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
Some properties are checked on every cycle:
- an event forces its pending bit high on the next cycle, even against a same-cycle acknowledge;
- an acknowledge with no competing event clears the bit;
- the mask holds when it is not written;
- a power-down write restores the reset words;
- bit 11 never rises without a high button level in the cycle before.

Other behaviour can only be shown by the bench scenarios:
- the full mapping from every mask pattern to the interrupt level;
- the rule that a steady button level raises nothing;
- that status writes are ignored;
- that unmapped addresses read back as zero.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int unsigned SRC_N  = 12;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned HI_W   = SRC_N - BYTE_W;

    typedef logic [SRC_N-1:0]  src_vec_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [7:0] {
        RA_MASK_LO  = 8'h00,
        RA_MASK_HI  = 8'h01,
        RA_STAT_LO  = 8'h02,
        RA_STAT_HI  = 8'h03,
        RA_ACK_LO   = 8'h04,
        RA_ACK_HI   = 8'h05,
        RA_PWR_DOWN = 8'h06
    } reg_addr_e;

    typedef struct packed {
        logic mask_lo;
        logic mask_hi;
        logic ack_lo;
        logic ack_hi;
        logic pwr_down;
    } wr_sel_t;

    localparam src_vec_t MASK_RST = '1;

    // Place a register byte into the low or high part of a source word.
    function automatic src_vec_t place_half(input byte_t b, input logic hi);
        src_vec_t w;
        w = src_vec_t'(b);
        return hi ? (w << BYTE_W) : w;
    endfunction

    // Bits of the source word that belong to the low or high register.
    function automatic src_vec_t half_bits(input logic hi);
        src_vec_t lo_m;
        lo_m = src_vec_t'({BYTE_W{1'b1}});
        return hi ? ~lo_m : lo_m;
    endfunction

    // Read view of one half of a source word, zero-extended to a byte.
    function automatic byte_t view_half(input src_vec_t w, input logic hi);
        byte_t b;
        b = hi ? byte_t'(w[SRC_N-1:BYTE_W]) : w[BYTE_W-1:0];
        return b;
    endfunction

endpackage

// File: rtl/irqagg_edge_det.sv
module irqagg_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/irqagg_mask_reg.sv
module irqagg_mask_reg
    import irqagg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     soft_clr_i,
    input  logic     wr_lo_i,
    input  logic     wr_hi_i,
    input  byte_t    wdata_i,
    output src_vec_t mask_o
);
    src_vec_t mask_q;
    src_vec_t wr_bits;
    src_vec_t wr_val;

    always_comb begin
        wr_bits = '0;
        wr_val  = '0;
        if (wr_lo_i) begin
            wr_bits = half_bits(1'b0);
            wr_val  = place_half(wdata_i, 1'b0);
        end else if (wr_hi_i) begin
            wr_bits = half_bits(1'b1);
            wr_val  = place_half(wdata_i, 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_clr_i) mask_q <= MASK_RST;
        else                   mask_q <= (mask_q & ~wr_bits) | (wr_val & wr_bits);
    end

    assign mask_o = mask_q;

    // R3: an unwritten mask keeps its value
    assert_mask_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!wr_lo_i && !wr_hi_i && !soft_clr_i) |=> $stable(mask_q));

    // R9: a power-down write restores the all-masked state
    assert_mask_pwrdn_R9: assert property (@(posedge clk) disable iff (rst)
        soft_clr_i |=> (mask_q == MASK_RST));
endmodule

// File: rtl/irqagg_status_bank.sv
module irqagg_status_bank
    import irqagg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     soft_clr_i,
    input  src_vec_t set_i,
    input  logic     ack_lo_i,
    input  logic     ack_hi_i,
    input  byte_t    wdata_i,
    output src_vec_t status_o
);
    src_vec_t clr_vec;
    src_vec_t stat_q;

    always_comb begin
        clr_vec = '0;
        if (ack_lo_i) clr_vec = place_half(wdata_i, 1'b0);
        if (ack_hi_i) clr_vec = place_half(wdata_i, 1'b1);
    end

    for (genvar i = 0; i < SRC_N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || soft_clr_i) stat_q[i] <= 1'b0;
            else if (set_i[i])     stat_q[i] <= 1'b1;
            else if (clr_vec[i])   stat_q[i] <= 1'b0;
        end

        // R6, R8: an event always lands, even against an acknowledge
        assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
            (set_i[i] && !soft_clr_i) |=> stat_q[i]);

        // R5: an acknowledge with no competing event clears the bit
        assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[i] && !set_i[i]) |=> !stat_q[i]);
    end

    assign status_o = stat_q;

    // R9: a power-down write empties the pending word
    assert_stat_pwrdn_R9: assert property (@(posedge clk) disable iff (rst)
        soft_clr_i |=> (stat_q == '0));
endmodule

// File: rtl/intr_aggregator.sv
module intr_aggregator
    import irqagg_pkg::*;
#(
    parameter int unsigned MISC_N = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MISC_N-1:0] evt_misc_i,
    input  logic              evt_tick_i,
    input  logic              evt_alarm_i,
    input  logic              evt_upd_err_i,
    input  logic              pwr_btn_i,
    input  logic [7:0]        addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic [7:0]        rdata_o,
    output logic              irq_o
);
    localparam int unsigned BIT_TICK  = MISC_N;
    localparam int unsigned BIT_ALARM = MISC_N + 1;
    localparam int unsigned BIT_UPERR = MISC_N + 2;
    localparam int unsigned BIT_PWR   = MISC_N + 3;

    wr_sel_t  wsel;
    logic     soft_clr;
    logic     pwr_rise;
    src_vec_t set_vec;
    src_vec_t mask_w;
    src_vec_t stat_w;

    always_comb begin
        wsel = '0;
        if (wr_i) begin
            case (addr_i)
                RA_MASK_LO:  wsel.mask_lo  = 1'b1;
                RA_MASK_HI:  wsel.mask_hi  = 1'b1;
                RA_ACK_LO:   wsel.ack_lo   = 1'b1;
                RA_ACK_HI:   wsel.ack_hi   = 1'b1;
                RA_PWR_DOWN: wsel.pwr_down = 1'b1;
                default:     wsel = '0;
            endcase
        end
    end

    assign soft_clr = wsel.pwr_down & wdata_i[0];

    irqagg_edge_det u_pwr_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (pwr_btn_i),
        .rise_o (pwr_rise)
    );

    always_comb begin
        set_vec                 = '0;
        set_vec[MISC_N-1:0]     = evt_misc_i;
        set_vec[BIT_TICK]       = evt_tick_i;
        set_vec[BIT_ALARM]      = evt_alarm_i;
        set_vec[BIT_UPERR]      = evt_upd_err_i;
        set_vec[BIT_PWR]        = pwr_rise;
    end

    irqagg_mask_reg u_mask (
        .clk        (clk),
        .rst        (rst),
        .soft_clr_i (soft_clr),
        .wr_lo_i    (wsel.mask_lo),
        .wr_hi_i    (wsel.mask_hi),
        .wdata_i    (wdata_i),
        .mask_o     (mask_w)
    );

    irqagg_status_bank u_stat (
        .clk        (clk),
        .rst        (rst),
        .soft_clr_i (soft_clr),
        .set_i      (set_vec),
        .ack_lo_i   (wsel.ack_lo),
        .ack_hi_i   (wsel.ack_hi),
        .wdata_i    (wdata_i),
        .status_o   (stat_w)
    );

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            case (addr_i)
                RA_MASK_LO: rdata_o = view_half(mask_w, 1'b0);
                RA_MASK_HI: rdata_o = view_half(mask_w, 1'b1);
                RA_STAT_LO: rdata_o = view_half(stat_w, 1'b0);
                RA_STAT_HI: rdata_o = view_half(stat_w, 1'b1);
                default:    rdata_o = '0;
            endcase
        end
    end

    assign irq_o = |(stat_w & ~mask_w);

    // R7: the button bit only rises after a high button level
    assert_pwr_edge_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_w[BIT_PWR]) |-> $past(pwr_btn_i));

    // R5: acknowledge registers never return data
    assert_ack_read_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_i && (addr_i == RA_ACK_LO || addr_i == RA_ACK_HI)) |-> (rdata_o == 8'h00));

    // R2: with every source masked no request is raised
    assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (mask_w == '1) |-> !irq_o);
endmodule

// File: tb/intr_aggregator_tb_top.sv
module intr_aggregator_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] evt_misc = '0;
    logic       evt_tick = 1'b0, evt_alarm = 1'b0, evt_err = 1'b0, pwr_btn = 1'b0;
    logic [7:0] addr = 8'hFF, wdata = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [11:0] exp_stat = '0;
    logic [11:0] exp_mask = 12'hFFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_aggregator dut_i (
        .clk(clk), .rst(rst), .evt_misc_i(evt_misc), .evt_tick_i(evt_tick),
        .evt_alarm_i(evt_alarm), .evt_upd_err_i(evt_err), .pwr_btn_i(pwr_btn),
        .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
        .rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; addr = 8'hFF;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        rd = 1'b0; addr = 8'hFF;
    endtask

    task automatic check_state(input string req);
        logic [7:0] v;
        reg_rd(8'h00, v); check(req, "mask lo", v, exp_mask[7:0]);
        reg_rd(8'h01, v); check(req, "mask hi", v, {4'h0, exp_mask[11:8]});
        reg_rd(8'h02, v); check(req, "stat lo", v, exp_stat[7:0]);
        reg_rd(8'h03, v); check(req, "stat hi", v, {4'h0, exp_stat[11:8]});
        check(req, "irq", irq, |(exp_stat & ~exp_mask));
    endtask

    task automatic set_mask(input logic [11:0] m);
        reg_wr(8'h00, m[7:0]);
        reg_wr(8'h01, {4'hA, m[11:8]});
        exp_mask = m;
    endtask

    task automatic fire(input int b);
        @(negedge clk);
        if (b < 8)        evt_misc[b] = 1'b1;
        else if (b == 8)  evt_tick  = 1'b1;
        else if (b == 9)  evt_alarm = 1'b1;
        else if (b == 10) evt_err   = 1'b1;
        else              pwr_btn   = 1'b1;
        @(negedge clk);
        evt_misc = '0; evt_tick = 1'b0; evt_alarm = 1'b0; evt_err = 1'b0; pwr_btn = 1'b0;
        exp_stat[b] = 1'b1;
    endtask

    task automatic ack_all;
        reg_wr(8'h04, 8'hFF);
        reg_wr(8'h05, 8'h0F);
        exp_stat = '0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset words
        check_state("R1");

        // R6 / R7 / R2 / R5: each source in turn
        for (int b = 0; b < 12; b++) begin
            fire(b);
            check_state(b == 11 ? "R7" : "R6");
            set_mask(~(12'h001 << b));
            check("R2", "irq unmasked", irq, 1);
            set_mask(12'hFFF);
            check("R2", "irq masked", irq, 0);
            if (b < 8) reg_wr(8'h04, 8'h01 << b);
            else       reg_wr(8'h05, 8'h01 << (b - 8));
            exp_stat[b] = 1'b0;
            check_state("R5");
        end

        // R3: halves independent, upper nibble data dropped
        reg_wr(8'h00, 8'h5A); exp_mask[7:0] = 8'h5A;
        check_state("R3");
        reg_wr(8'h01, 8'hA3); exp_mask[11:8] = 4'h3;
        check_state("R3");

        // R2: sweep every high-nibble mask with bits 11:8 pending
        for (int b = 8; b < 12; b++) fire(b);
        for (int m = 0; m < 16; m++) begin
            reg_wr(8'h00, 8'hFF); reg_wr(8'h01, m[7:0]);
            exp_mask = {m[3:0], 8'hFF};
            check("R2", "irq hi sweep", irq, (m != 15) ? 1 : 0);
        end
        ack_all();

        // R2: sweep every low-byte mask against a fixed pending pattern
        @(negedge clk); evt_misc = 8'hA5;
        @(negedge clk); evt_misc = '0; exp_stat[7:0] = 8'hA5;
        for (int m = 0; m < 256; m++) begin
            reg_wr(8'h00, m[7:0]);
            exp_mask[7:0] = m[7:0];
            check("R2", "irq lo sweep", irq, ((8'hA5 & ~m[7:0]) != 0) ? 1 : 0);
        end

        // R4: writes to the pending registers are ignored
        reg_wr(8'h02, 8'h00); reg_wr(8'h03, 8'h0F);
        check_state("R4");
        ack_all();

        // R5 / R9 / R10: read-as-zero addresses
        reg_rd(8'h04, v); check("R5", "ack lo read", v, 0);
        reg_rd(8'h05, v); check("R5", "ack hi read", v, 0);
        reg_rd(8'h06, v); check("R9", "pwr-down read", v, 0);
        for (int a = 7; a < 256; a++) begin
            reg_rd(a[7:0], v); check("R10", "unmapped read", v, 0);
        end
        set_mask(12'h000);
        @(negedge clk); #1 check("R10", "rd low", rdata, 0);

        // R8: event and acknowledge of the same bit in one cycle
        fire(8); fire(3);
        @(negedge clk);
        addr = 8'h05; wdata = 8'h01; wr = 1'b1; evt_tick = 1'b1;
        @(negedge clk);
        addr = 8'h04; wdata = 8'h08; evt_tick = 1'b0; evt_misc = 8'h08;
        @(negedge clk);
        wr = 1'b0; evt_misc = '0; addr = 8'hFF;
        check_state("R8");
        ack_all();

        // R7: steady high and falling edge set nothing more
        @(negedge clk); pwr_btn = 1'b1;
        @(negedge clk); exp_stat[11] = 1'b1;
        check("R7", "rise sets", irq, 1);
        reg_wr(8'h05, 8'h08); exp_stat[11] = 1'b0;
        repeat (6) @(negedge clk);
        check_state("R7");
        pwr_btn = 1'b0;
        repeat (4) @(negedge clk);
        check_state("R7");

        // R9: power-down register
        fire(0); fire(10); set_mask(12'h3C3);
        reg_wr(8'h06, 8'hFE);
        check_state("R9");
        reg_wr(8'h06, 8'h01);
        exp_mask = 12'hFFF; exp_stat = '0;
        check_state("R9");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule